// File: doc/BRIEF.md
# Twelve-Line Parallel Port with Edge Interrupts

This block is a 12-line general-purpose parallel port behind a small register bus. Each line can act as a plain input, a plain push-pull output, or a dedicated peripheral signal. One extra mode lets an input line feed a peripheral's modem-control input, such as clear-to-send or carrier-detect, and raise an edge interrupt from the same pin at the same time.

Pin levels pass through a two-flop synchronizer. The synchronized level is then checked for the edges selected per line. Each detected edge sets a pending flag, and software clears the flag by writing a 1 to it. The flags are ANDed with a per-line mask and ORed together into one interrupt output. The lines sit in bits 15..4 of every 16-bit register, with line k at bit k+4. Bits 3..0 are unused.

Register map (word address on `addr_i`): 0 = level read / output latch write, 1 = direction, 2 = peripheral assignment, 3 = modem option, 4 = edge select, 5 = interrupt mask, 6 = pending events (write 1 to clear). Address 7 reads zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register is zero. All lines are inputs, `pin_oe_o` is 0, `per_din_o` is 0 and `irq_o` is 0.
- R2: Read data bits 3..0 are always 0. Line k always maps to bit k+4.
- R3: A read of address 0 returns the two-flop-synchronized level of every line, whatever its direction or assignment. Read data is registered and appears one cycle after the address.
- R4: A line with direction 1 and assignment 0 drives the output latch on `pin_o`. `pin_oe_o` stays 1 for both levels, so there is no open-drain behaviour.
- R5: A line with assignment 1 serves the peripheral. With direction 1 it drives `per_dout_i` with the output enabled. With direction 0 its synchronized level appears on `per_din_o`.
- R6: A line with assignment 0, direction 0 and option 1 passes its synchronized level to `per_din_o` and still produces edge events. With option 0 and assignment 0, that `per_din_o` bit is 0.
- R7: An edge-select bit of 0 sets the event on any edge. A bit of 1 sets the event on falling edges only.
- R8: An event bit sets on the third rising clock edge after the pin changes. Writing 1 to that bit at address 6 clears it, and writing 0 leaves it unchanged.
- R9: `irq_o` is 1 exactly when some event bit and its mask bit are both 1.
- R10: A line with direction 1 or assignment 1 never sets an event.
- R11: Addresses 1 to 5 read back the last value written, with bits 3..0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| pin_i | input | 12 | Pad input levels |
| pin_o | output | 12 | Pad output levels |
| pin_oe_o | output | 12 | Pad output enables |
| per_dout_i | input | 12 | Peripheral output signals |
| per_din_o | output | 12 | Signals routed to peripheral inputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that `pin_i` may change at any time. They also assume that a write clears the events only in the cycle `wr_i` is high with address 6. The event properties assume that the edge-select and enable settings were stable in the cycle before an event appears, because they compare against the previous cycle's values. The bench keeps inside these assumptions. It changes pins and drives bus inputs only on falling clock edges, and it lets several cycles pass after a configuration write before it toggles a pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_ASG   = 3'd2,
    REG_OPT   = 3'd3,
    REG_EDGE  = 3'd4,
    REG_MASK  = 3'd5,
    REG_EVT   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] fall_only_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] prev_q, evt_q, hit;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      hit[i] = en_i[i] & (fall_only_i[i] ? (prev_q[i] & ~lvl_i[i])
                                         : (prev_q[i] ^ lvl_i[i]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      evt_q  <= (evt_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign evt_o = evt_q;

  AST_EVT_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(evt_q)) & ~$past(en_i)) == '0);  // R10
  AST_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(evt_q)) & $past(fall_only_i) & $past(lvl_i)) == '0);  // R7
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) & ~$past(hit) & evt_q) == '0);  // R8
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_LINES = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  input  logic [NUM_LINES-1:0] per_dout_i,
  output logic [NUM_LINES-1:0] per_din_o,
  output logic                 irq_o
);
  localparam int unsigned LSB = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] out_q, dir_q, asg_q, opt_q, edge_q, mask_q;
  logic [NUM_LINES-1:0] lvl, evt, clr, evt_en;
  logic [NUM_LINES-1:0] wfield;

  assign wfield = wdata_i[DATA_W-1:LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      asg_q  <= '0;
      opt_q  <= '0;
      edge_q <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_LEVEL: out_q  <= wfield;
        REG_DIR:   dir_q  <= wfield;
        REG_ASG:   asg_q  <= wfield;
        REG_OPT:   opt_q  <= wfield;
        REG_EDGE:  edge_q <= wfield;
        REG_MASK:  mask_q <= wfield;
        default: ;
      endcase
    end
  end

  assign clr = (wr_i && addr_i == REG_EVT) ? wfield : '0;

  gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign evt_en = ~dir_q & ~asg_q;

  gpio_edge_detect #(.WIDTH(NUM_LINES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .en_i       (evt_en),
    .fall_only_i(edge_q),
    .clr_i      (clr),
    .evt_o      (evt)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_comb begin
      pin_oe_o[g]  = dir_q[g];
      pin_o[g]     = asg_q[g] ? per_dout_i[g] : out_q[g];
      per_din_o[g] = ~dir_q[g] & (asg_q[g] | opt_q[g]) & lvl[g];
    end
  end

  assign irq_o = |(evt & mask_q);

  logic [NUM_LINES-1:0] rfield;
  always_comb begin
    case (addr_i)
      REG_LEVEL: rfield = lvl;
      REG_DIR:   rfield = dir_q;
      REG_ASG:   rfield = asg_q;
      REG_OPT:   rfield = opt_q;
      REG_EDGE:  rfield = edge_q;
      REG_MASK:  rfield = mask_q;
      REG_EVT:   rfield = evt;
      default:   rfield = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= {rfield, {LSB{1'b0}}};
  end

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);  // R9
  AST_RD_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[LSB-1:0] == '0);  // R2
  AST_IN_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && addr_i == REG_DIR && wfield == '0) |-> pin_oe_o == '0);  // R1
endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0, wr = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [11:0] pin = 0, pin_o, pin_oe, per_dout = 0, per_din;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .per_dout_i(per_dout), .per_din_o(per_din), .irq_o(irq)
  );

  localparam logic [18:0] VEC [6] = '{
    {3'd1, 16'hFFFF}, {3'd2, 16'h5A5F}, {3'd3, 16'h0F0F},
    {3'd4, 16'hA5A0}, {3'd5, 16'h1234}, {3'd1, 16'h8001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; wr = 0;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic set_pin(input logic [11:0] p);
    @(negedge clk); pin = p;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1 oe", {4'h0, pin_oe}, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 per_din", {4'h0, per_din}, 16'h0);
    @(negedge clk); rst_ni = 1;
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), r);
      check("R1 reg zero", r, 16'h0);
    end

    // R11 / R2 register table
    for (int i = 0; i < 6; i++) begin
      wr_reg(VEC[i][18:16], VEC[i][15:0]);
      rd_reg(VEC[i][18:16], r);
      check("R11 readback", r, VEC[i][15:0] & 16'hFFF0);
    end
    for (int a = 1; a < 6; a++) wr_reg(3'(a), 16'h0);

    // R4 push-pull output
    wr_reg(3'd1, 16'hFFF0);
    wr_reg(3'd0, 16'hA5A0);
    #1;
    check("R4 pin_o", {4'h0, pin_o}, 16'h0A5A);
    check("R4 oe", {4'h0, pin_oe}, 16'h0FFF);
    wr_reg(3'd0, 16'h0000);
    #1;
    check("R4 drive low oe", {4'h0, pin_oe}, 16'h0FFF);
    check("R4 drive low", {4'h0, pin_o}, 16'h0);

    // R3 level read with outputs enabled
    set_pin(12'h5C3);
    rd_reg(3'd0, r);
    check("R3 level dir=1", r, 16'h5C30);
    wr_reg(3'd1, 16'h0);
    set_pin(12'h0);
    wr_reg(3'd6, 16'hFFF0);
    set_pin(12'h9A1);
    rd_reg(3'd0, r);
    check("R3 level dir=0", r, 16'h9A10);
    set_pin(12'h0);
    wr_reg(3'd6, 16'hFFF0);
    rd_reg(3'd6, r);
    check("R8 clear all", r, 16'h0);

    // R5 peripheral routing: line 2 out, line 3 in
    wr_reg(3'd2, 16'h00C0);
    wr_reg(3'd1, 16'h0040);
    @(negedge clk); per_dout = 12'h004;
    #1;
    check("R5 per out", {4'h0, pin_o & 12'h004}, 16'h0004);
    check("R5 per oe", {4'h0, pin_oe}, 16'h0004);
    set_pin(12'h008);
    check("R5 per in", {4'h0, per_din}, 16'h0008);
    rd_reg(3'd6, r);
    check("R10 asg no evt", r, 16'h0);
    set_pin(12'h0);
    wr_reg(3'd2, 16'h0); wr_reg(3'd1, 16'h0);
    @(negedge clk); per_dout = 0;

    // R6 modem option on line 5 (bit 9)
    wr_reg(3'd3, 16'h0200);
    set_pin(12'h020);
    check("R6 per_din follows", {4'h0, per_din}, 16'h0020);
    rd_reg(3'd6, r);
    check("R6 R7 rise evt any-edge", r, 16'h0200);
    wr_reg(3'd6, 16'h0000);
    rd_reg(3'd6, r);
    check("R8 write 0 keeps", r, 16'h0200);
    wr_reg(3'd6, 16'h0200);
    rd_reg(3'd6, r);
    check("R8 w1c", r, 16'h0);
    wr_reg(3'd5, 16'h0200);
    #1;
    check("R9 irq idle", {15'h0, irq}, 16'h0);
    set_pin(12'h000);
    check("R9 irq set", {15'h0, irq}, 16'h1);
    wr_reg(3'd6, 16'h0200);
    #1;
    check("R9 irq clear", {15'h0, irq}, 16'h0);

    // R7 falling only
    wr_reg(3'd4, 16'h0200);
    set_pin(12'h020);
    rd_reg(3'd6, r);
    check("R7 no rise evt", r, 16'h0);
    set_pin(12'h000);
    rd_reg(3'd6, r);
    check("R7 fall evt", r, 16'h0200);
    wr_reg(3'd6, 16'h0200);
    wr_reg(3'd4, 16'h0);

    // R8 timing: set on 3rd edge after pin change
    @(negedge clk); pin = 12'h020;
    repeat (2) @(posedge clk);
    #1 check("R8 not yet", {15'h0, irq}, 16'h0);
    @(posedge clk);
    #1 check("R8 third edge", {15'h0, irq}, 16'h1);
    wr_reg(3'd6, 16'h0200);

    // R6 option off
    wr_reg(3'd3, 16'h0);
    #1;
    check("R6 opt off", {4'h0, per_din}, 16'h0);

    // R10 outputs set no events
    wr_reg(3'd1, 16'h0200);
    set_pin(12'h000);
    set_pin(12'h020);
    rd_reg(3'd6, r);
    check("R10 dir no evt", r, 16'h0);

    rd_reg(3'd7, r);
    check("R2 unused addr", r, 16'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule